// File: doc/BRIEF.md
# DDR SDRAM Command Sequence Monitor

This block watches the command bus between a memory controller and a four-bank DDR SDRAM. Every rising clock edge it samples the clock-enable line (and keeps its value from the previous edge), the active-low select and the three strobes, the bank address, the auto-precharge/all-banks address bit and the three low opcode bits. From these it names the command, works out which bank that command addresses, and checks the command against the state it keeps for each bank and for the device as a whole.

The monitor holds a power/sequencing state machine with the states RUN (normal operation), LOCK (settling window after a mode-register write), PDN_PRE (power-down with all banks closed), PDN_ACT (power-down with a bank open) and SREF (self refresh). Its transitions are: RUN to LOCK on an accepted mode or extended mode set, LOCK back to RUN when the window has run out, RUN to PDN_PRE or PDN_ACT when clock-enable falls on a non-refresh cycle, RUN to SREF when clock-enable falls on a refresh cycle, and PDN_PRE, PDN_ACT or SREF back to RUN when clock-enable rises. Beside it, a bank tracker keeps an open/closed bit per bank and times one auto-precharge burst, whose length comes from the last mode-register write. A command that breaks a rule is reported with a violation code and leaves all state untouched. The monitor has no data path.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With clock-enable high at this edge and the one before and sel_n low, the strobes {row_stb_n, col_stb_n, wr_stb_n} decode as: 000 mode set (cmd 2, or 3 extended when bank_addr[0] is 1), 001 refresh (4), 011 activate (7), 101 read (8, or 9 when ap_flag is 1), 100 write (10, or 11 when ap_flag is 1), 110 burst stop (12), 010 precharge (13, or 14 when ap_flag is 1), 111 no-op (1); sel_n high gives deselect (0).
- R2: For activate, read, write and single-bank precharge, bank_o is one-hot with bank_addr 00 giving bit 0, 10 giving bit 1, 01 giving bit 2 and 11 giving bit 3; precharge-all gives 4'b1111; every other command gives 4'b0000.
- R3: An accepted mode set (cmd 2) with op_lo 1, 2 or 3 sets the burst length to 2, 4 or 8; other op_lo values and extended mode set leave it unchanged; after reset it is 2.
- R4: In each of the two cycles after an accepted mode or extended mode set, any command other than no-op or deselect gets violation code 2.
- R5: Mode set, extended mode set, auto refresh and self-refresh entry while any bank is open get violation code 1.
- R6: After an accepted read or write with auto-precharge, the bank stays open for burst-length/2 further cycles; any read or write in those cycles gets violation code 3, and the bank is closed when they end.
- R7: A read or write to a closed bank gets violation code 4; an activate to an open bank gets violation code 5.
- R8: Precharge with ap_flag low closes only the selected bank; with ap_flag high it closes every bank and bank_addr has no effect.
- R9: Clock-enable falling on a cycle with the refresh encoding enters self refresh (cmd 5); while clock-enable stays low cmd is 18; clock-enable rising leaves self refresh (cmd 6).
- R10: Clock-enable falling on any other cycle enters power-down, cmd 15 when all banks are closed and 16 otherwise; clock-enable rising leaves it with cmd 17.
- R11: Deselect and burst stop never raise a violation outside the lockout window, at any burst length, and change no bank state.
- R12: Outputs are registered and describe the command sampled at the previous rising edge; reset drives cmd_o, bank_o and viol_o to 0; viol_o 0 means no violation; a violating command changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Clock-enable line of the memory |
| sel_n | input | 1 | Active-low device select |
| row_stb_n | input | 1 | Active-low row strobe |
| col_stb_n | input | 1 | Active-low column strobe |
| wr_stb_n | input | 1 | Active-low write strobe |
| bank_addr | input | 2 | Bank address |
| ap_flag | input | 1 | Auto-precharge / all-banks address bit |
| op_lo | input | 3 | Low opcode bits, burst length field on mode set |
| cmd_o | output | 5 | Decoded command code |
| bank_o | output | 4 | One-hot selected bank |
| viol_o | output | 3 | Violation code, 0 when legal |

## Verification
The close of an auto-precharge burst and a new command to the same bank can land on the same edge: the last cycle of the window still rejects a read, while the very next edge already sees the bank closed. The bench provokes this with a read-with-auto-precharge followed by back-to-back write, burst stop and read to that bank at burst lengths 4 and 8, and again through random command streams that mix activates, precharges and mode writes. Each cycle is judged against a bench model of the bank bits, the burst countdown and the lockout window that predicts the code, bank mask and violation for that edge.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

    localparam int NBANK    = 4;
    localparam int BA_W     = 2;
    localparam int BLF_W    = 3;
    localparam int BCNT_W   = 3;

    typedef enum logic [4:0] {
        CMD_DESEL      = 5'd0,
        CMD_NOP        = 5'd1,
        CMD_MRS        = 5'd2,
        CMD_EMRS       = 5'd3,
        CMD_REF        = 5'd4,
        CMD_SREF_IN    = 5'd5,
        CMD_SREF_OUT   = 5'd6,
        CMD_ACT        = 5'd7,
        CMD_RD         = 5'd8,
        CMD_RDA        = 5'd9,
        CMD_WR         = 5'd10,
        CMD_WRA        = 5'd11,
        CMD_BST        = 5'd12,
        CMD_PRE        = 5'd13,
        CMD_PREA       = 5'd14,
        CMD_PDN_PRE_IN = 5'd15,
        CMD_PDN_ACT_IN = 5'd16,
        CMD_PDN_OUT    = 5'd17,
        CMD_IDLE_LOW   = 5'd18
    } cmd_e;

    typedef enum logic [2:0] {
        V_NONE      = 3'd0,
        V_NOT_IDLE  = 3'd1,
        V_LOCKOUT   = 3'd2,
        V_AP_BURST  = 3'd3,
        V_BANK_IDLE = 3'd4,
        V_BANK_OPEN = 3'd5
    } viol_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_LOCK,
        ST_PDN_PRE,
        ST_PDN_ACT,
        ST_SREF
    } pwr_e;

    // bank_addr {hi,lo} -> bank index: 00->0, 10->1, 01->2, 11->3
    function automatic logic [BA_W-1:0] bank_idx(input logic [BA_W-1:0] ba);
        return {ba[0], ba[1]};
    endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_cmd_pkg::*;
(
    input  logic clk_en_q,
    input  logic clk_en,
    input  logic sel_n,
    input  logic row_stb_n,
    input  logic col_stb_n,
    input  logic wr_stb_n,
    input  logic ba_lo,
    input  logic ap_flag,
    input  logic all_idle,
    input  pwr_e state,
    output cmd_e cmd
);

    logic is_ref_code;
    assign is_ref_code = !sel_n && !row_stb_n && !col_stb_n && wr_stb_n;

    always_comb begin
        cmd = CMD_NOP;
        if (!clk_en_q) begin
            if (!clk_en)
                cmd = CMD_IDLE_LOW;
            else if (state == ST_SREF)
                cmd = CMD_SREF_OUT;
            else if (state == ST_PDN_PRE || state == ST_PDN_ACT)
                cmd = CMD_PDN_OUT;
            else
                cmd = CMD_NOP;
        end else if (!clk_en) begin
            if (is_ref_code)
                cmd = CMD_SREF_IN;
            else if (all_idle)
                cmd = CMD_PDN_PRE_IN;
            else
                cmd = CMD_PDN_ACT_IN;
        end else if (sel_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({row_stb_n, col_stb_n, wr_stb_n})
                3'b000: cmd = ba_lo ? CMD_EMRS : CMD_MRS;
                3'b001: cmd = CMD_REF;
                3'b011: cmd = CMD_ACT;
                3'b101: cmd = ap_flag ? CMD_RDA : CMD_RD;
                3'b100: cmd = ap_flag ? CMD_WRA : CMD_WR;
                3'b110: cmd = CMD_BST;
                3'b010: cmd = ap_flag ? CMD_PREA : CMD_PRE;
                3'b111: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ddr_pwr_fsm.sv
module ddr_pwr_fsm
    import ddr_cmd_pkg::*;
#(
    parameter int LOCK_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd,
    input  logic accepted,
    output pwr_e state
);

    localparam int CW = $clog2(LOCK_CLKS + 1);

    pwr_e          state_q;
    pwr_e          state_d;
    logic [CW-1:0] lock_cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (accepted) begin
                    case (cmd)
                        CMD_MRS, CMD_EMRS: state_d = ST_LOCK;
                        CMD_SREF_IN:       state_d = ST_SREF;
                        CMD_PDN_PRE_IN:    state_d = ST_PDN_PRE;
                        CMD_PDN_ACT_IN:    state_d = ST_PDN_ACT;
                        default:           state_d = ST_RUN;
                    endcase
                end
            end
            ST_LOCK: begin
                if (lock_cnt_q == '0)
                    state_d = ST_RUN;
            end
            ST_PDN_PRE, ST_PDN_ACT: begin
                if (cmd == CMD_PDN_OUT)
                    state_d = ST_RUN;
            end
            ST_SREF: begin
                if (cmd == CMD_SREF_OUT)
                    state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_RUN;
            lock_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_LOCK && state_q != ST_LOCK)
                lock_cnt_q <= CW'(LOCK_CLKS - 1);
            else if (state_q == ST_LOCK && lock_cnt_q != '0)
                lock_cnt_q <= lock_cnt_q - 1'b1;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track #(
    parameter int NB    = 4,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NB-1:0]    open_vec,
    input  logic [NB-1:0]    close_vec,
    input  logic             ap_start,
    input  logic [NB-1:0]    ap_vec,
    input  logic [CNT_W-1:0] ap_clks,
    output logic [NB-1:0]    active,
    output logic             ap_busy
);

    logic [NB-1:0]    active_q;
    logic [NB-1:0]    ap_bank_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done;
    logic             cut;

    assign done = busy_q && (cnt_q == '0);
    assign cut  = busy_q && |(close_vec & ap_bank_q);

    for (genvar i = 0; i < NB; i++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                active_q[i] <= 1'b0;
            else
                active_q[i] <= (active_q[i] & ~(close_vec[i] | (done & ap_bank_q[i])))
                             | open_vec[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            cnt_q     <= '0;
            ap_bank_q <= '0;
        end else if (ap_start) begin
            busy_q    <= 1'b1;
            cnt_q     <= ap_clks - 1'b1;
            ap_bank_q <= ap_vec;
        end else if (cut || done) begin
            busy_q    <= 1'b0;
        end else if (busy_q) begin
            cnt_q     <= cnt_q - 1'b1;
        end
    end

    assign active  = active_q;
    assign ap_busy = busy_q;

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
    import ddr_cmd_pkg::*;
#(
    parameter int LOCK_CLKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_en,
    input  logic       sel_n,
    input  logic       row_stb_n,
    input  logic       col_stb_n,
    input  logic       wr_stb_n,
    input  logic [1:0] bank_addr,
    input  logic       ap_flag,
    input  logic [2:0] op_lo,
    output logic [4:0] cmd_o,
    output logic [3:0] bank_o,
    output logic [2:0] viol_o
);

    logic              clk_en_q;
    logic [BLF_W-1:0]  bl_code_q;
    logic [BCNT_W-1:0] half_len;
    logic [NBANK-1:0]  active;
    logic [NBANK-1:0]  sel_vec;
    logic [NBANK-1:0]  open_vec;
    logic [NBANK-1:0]  close_vec;
    logic [NBANK-1:0]  bank_d;
    logic              ap_busy;
    logic              all_idle;
    logic              accepted;
    logic              ap_start;
    logic [BA_W-1:0]   idx;
    cmd_e              cmd;
    viol_e             viol;
    pwr_e              state;

    assign idx      = bank_idx(bank_addr);
    assign sel_vec  = NBANK'(1) << idx;
    assign all_idle = (active == '0);

    ddr_cmd_decode u_dec (
        .clk_en_q  (clk_en_q),
        .clk_en    (clk_en),
        .sel_n     (sel_n),
        .row_stb_n (row_stb_n),
        .col_stb_n (col_stb_n),
        .wr_stb_n  (wr_stb_n),
        .ba_lo     (bank_addr[0]),
        .ap_flag   (ap_flag),
        .all_idle  (all_idle),
        .state     (state),
        .cmd       (cmd)
    );

    ddr_pwr_fsm #(.LOCK_CLKS(LOCK_CLKS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .accepted (accepted),
        .state    (state)
    );

    // rule check
    always_comb begin
        viol = V_NONE;
        if (state == ST_LOCK && !(cmd inside {CMD_NOP, CMD_DESEL})) begin
            viol = V_LOCKOUT;
        end else begin
            case (cmd)
                CMD_MRS, CMD_EMRS, CMD_REF, CMD_SREF_IN: begin
                    if (!all_idle) viol = V_NOT_IDLE;
                end
                CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: begin
                    if (ap_busy)           viol = V_AP_BURST;
                    else if (!active[idx]) viol = V_BANK_IDLE;
                end
                CMD_ACT: begin
                    if (active[idx]) viol = V_BANK_OPEN;
                end
                default: viol = V_NONE;
            endcase
        end
    end

    assign accepted  = (viol == V_NONE);
    assign open_vec  = (accepted && cmd == CMD_ACT) ? sel_vec : '0;
    assign close_vec = !accepted            ? '0 :
                       (cmd == CMD_PRE)     ? sel_vec :
                       (cmd == CMD_PREA)    ? '1 : '0;
    assign ap_start  = accepted && (cmd == CMD_RDA || cmd == CMD_WRA);

    always_comb begin
        case (bl_code_q)
            3'd2:    half_len = BCNT_W'(2);
            3'd3:    half_len = BCNT_W'(4);
            default: half_len = BCNT_W'(1);
        endcase
    end

    ddr_bank_track #(.NB(NBANK), .CNT_W(BCNT_W)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_vec  (open_vec),
        .close_vec (close_vec),
        .ap_start  (ap_start),
        .ap_vec    (sel_vec),
        .ap_clks   (half_len),
        .active    (active),
        .ap_busy   (ap_busy)
    );

    always_comb begin
        case (cmd)
            CMD_ACT, CMD_RD, CMD_RDA, CMD_WR, CMD_WRA, CMD_PRE: bank_d = sel_vec;
            CMD_PREA: bank_d = '1;
            default:  bank_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_en_q  <= 1'b1;
            bl_code_q <= BLF_W'(1);
        end else begin
            clk_en_q <= clk_en;
            if (accepted && cmd == CMD_MRS && op_lo inside {3'd1, 3'd2, 3'd3})
                bl_code_q <= op_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_o  <= '0;
            bank_o <= '0;
            viol_o <= '0;
        end else begin
            cmd_o  <= cmd;
            bank_o <= bank_d;
            viol_o <= viol;
        end
    end

endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk
    import ddr_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] cmd_o,
    input logic [3:0] bank_o,
    input logic [2:0] viol_o
);

    AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o inside {CMD_ACT, CMD_RD, CMD_RDA, CMD_WR, CMD_WRA, CMD_PRE})
        |-> $countones(bank_o) == 1); // R2

    AST_PREA_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_PREA) |-> (bank_o == 4'hF)); // R8

    AST_MRS_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o inside {CMD_MRS, CMD_EMRS}) && viol_o == V_NONE)
        |=> ((cmd_o inside {CMD_NOP, CMD_DESEL}) || viol_o == V_LOCKOUT)); // R4

    AST_DESEL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_DESEL) |-> (viol_o == V_NONE && bank_o == 4'h0)); // R11

    AST_BST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_BST) |-> (viol_o inside {V_NONE, V_LOCKOUT})); // R11

    AST_SREF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_SREF_IN && viol_o == V_NONE)
        |=> (cmd_o inside {CMD_IDLE_LOW, CMD_SREF_OUT})); // R9

    AST_PDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o inside {CMD_PDN_PRE_IN, CMD_PDN_ACT_IN}) && viol_o == V_NONE)
        |=> (cmd_o inside {CMD_IDLE_LOW, CMD_PDN_OUT})); // R10

    AST_AP_NO_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o inside {CMD_RDA, CMD_WRA}) && viol_o == V_NONE)
        |=> !((cmd_o inside {CMD_RD, CMD_RDA, CMD_WR, CMD_WRA}) && viol_o == V_NONE)); // R6

endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_o  (cmd_o),
    .bank_o (bank_o),
    .viol_o (viol_o)
);

// File: tb/sim_ddr_cmd_monitor.sv
module sim_ddr_cmd_monitor;
    import ddr_cmd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int LOCKN      = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b1, sel_n = 1'b1, row_stb_n = 1'b1, col_stb_n = 1'b1, wr_stb_n = 1'b1;
    logic [1:0] bank_addr = '0;
    logic       ap_flag = 1'b0;
    logic [2:0] op_lo = '0;
    logic [4:0] cmd_o;
    logic [3:0] bank_o;
    logic [2:0] viol_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // bench model state
    logic       m_ckeq = 1'b1;
    logic [3:0] m_act  = '0;
    logic       m_busy = 1'b0;
    int         m_cnt  = 0;
    int         m_apb  = 0;
    int         m_half = 1;
    int         m_st   = 0;   // 0 run, 1 lock, 2 pd closed, 3 pd open, 4 self refresh
    int         m_lock = 0;

    ddr_cmd_monitor #(.LOCK_CLKS(LOCKN)) u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel_n(sel_n),
        .row_stb_n(row_stb_n), .col_stb_n(col_stb_n), .wr_stb_n(wr_stb_n),
        .bank_addr(bank_addr), .ap_flag(ap_flag), .op_lo(op_lo),
        .cmd_o(cmd_o), .bank_o(bank_o), .viol_o(viol_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [4:0] exp_decode(input logic ck, cs, r, c, w, input logic ba0, ap, idle);
        if (!m_ckeq) begin
            if (!ck) return CMD_IDLE_LOW;
            if (m_st == 4) return CMD_SREF_OUT;
            if (m_st == 2 || m_st == 3) return CMD_PDN_OUT;
            return CMD_NOP;
        end
        if (!ck) begin
            if (!cs && !r && !c && w) return CMD_SREF_IN;
            return idle ? CMD_PDN_PRE_IN : CMD_PDN_ACT_IN;
        end
        if (cs) return CMD_DESEL;
        case ({r, c, w})
            3'b000: return ba0 ? CMD_EMRS : CMD_MRS;
            3'b001: return CMD_REF;
            3'b011: return CMD_ACT;
            3'b101: return ap ? CMD_RDA : CMD_RD;
            3'b100: return ap ? CMD_WRA : CMD_WR;
            3'b110: return CMD_BST;
            3'b010: return ap ? CMD_PREA : CMD_PRE;
            default: return CMD_NOP;
        endcase
    endfunction

    task automatic check(input string tag, input logic [4:0] ec, input logic [3:0] eb, input logic [2:0] ev);
        n_chk++;
        if (cmd_o !== ec || bank_o !== eb || viol_o !== ev) begin
            n_bad++;
            $display("FAIL %s: cmd/bank/viol actual %0d/%b/%0d expected %0d/%b/%0d",
                     tag, cmd_o, bank_o, viol_o, ec, eb, ev);
        end
    endtask

    task automatic step(input logic ck, cs, r, c, w, input logic [1:0] b, input logic ap,
                        input logic [2:0] op, input string tag);
        int         idx;
        logic [4:0] ec;
        logic [3:0] eb;
        logic [2:0] ev;
        logic [3:0] one;
        logic [3:0] cm;
        logic       done;
        idx = (b == 2'b00) ? 0 : (b == 2'b10) ? 1 : (b == 2'b01) ? 2 : 3;
        one = 4'b0001 << idx;
        ec  = exp_decode(ck, cs, r, c, w, b[0], ap, m_act == 4'b0);
        eb  = (ec inside {CMD_ACT, CMD_RD, CMD_RDA, CMD_WR, CMD_WRA, CMD_PRE}) ? one :
              (ec == CMD_PREA) ? 4'hF : 4'h0;
        ev  = V_NONE;
        if (m_st == 1 && !(ec inside {CMD_NOP, CMD_DESEL})) ev = V_LOCKOUT;
        else if ((ec inside {CMD_MRS, CMD_EMRS, CMD_REF, CMD_SREF_IN}) && m_act != 0) ev = V_NOT_IDLE;
        else if (ec inside {CMD_RD, CMD_RDA, CMD_WR, CMD_WRA})
            ev = m_busy ? V_AP_BURST : (!m_act[idx] ? V_BANK_IDLE : V_NONE);
        else if (ec == CMD_ACT && m_act[idx]) ev = V_BANK_OPEN;
        // next model state
        done = m_busy && m_cnt == 0;
        cm   = (ev != V_NONE) ? 4'h0 : (ec == CMD_PRE) ? one : (ec == CMD_PREA) ? 4'hF : 4'h0;
        m_act = (m_act & ~(cm | (done ? (4'b0001 << m_apb) : 4'h0)))
              | ((ev == V_NONE && ec == CMD_ACT) ? one : 4'h0);
        if (ev == V_NONE && (ec == CMD_RDA || ec == CMD_WRA)) begin
            m_busy = 1'b1; m_cnt = m_half - 1; m_apb = idx;
        end else if (m_busy && (cm[m_apb] || done)) begin
            m_busy = 1'b0;
        end else if (m_busy) begin
            m_cnt--;
        end
        if (ev == V_NONE && ec == CMD_MRS && op inside {3'd1, 3'd2, 3'd3})
            m_half = 1 << (op - 1);
        case (m_st)
            0: if (ev == V_NONE) begin
                   if (ec inside {CMD_MRS, CMD_EMRS}) begin m_st = 1; m_lock = LOCKN - 1; end
                   else if (ec == CMD_SREF_IN)    m_st = 4;
                   else if (ec == CMD_PDN_PRE_IN) m_st = 2;
                   else if (ec == CMD_PDN_ACT_IN) m_st = 3;
               end
            1: if (m_lock == 0) m_st = 0; else m_lock--;
            2, 3: if (ec == CMD_PDN_OUT) m_st = 0;
            4: if (ec == CMD_SREF_OUT) m_st = 0;
            default: m_st = 0;
        endcase
        m_ckeq = ck;
        clk_en = ck; sel_n = cs; row_stb_n = r; col_stb_n = c; wr_stb_n = w;
        bank_addr = b; ap_flag = ap; op_lo = op;
        @(posedge clk);
        @(negedge clk);
        check(tag, ec, eb, ev);
    endtask

    // shorthand: {ras,cas,we}
    task automatic cmd(input logic [2:0] rcw, input logic [1:0] b, input logic ap, input logic [2:0] op,
                       input string tag);
        step(1'b1, 1'b0, rcw[2], rcw[1], rcw[0], b, ap, op, tag);
    endtask

    localparam logic [2:0] K_MRS = 3'b000, K_REF = 3'b001, K_ACT = 3'b011, K_RD = 3'b101,
                           K_WR = 3'b100, K_BST = 3'b110, K_PRE = 3'b010, K_NOP = 3'b111;

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        check("R12 reset", 5'd0, 4'h0, 3'd0);
        rst_n = 1'b1;

        // mode set, lockout, rejected command leaves no state
        cmd(K_MRS, 2'b00, 1'b0, 3'd2, "R3 mode set BL4");
        cmd(K_NOP, 2'b00, 1'b0, 3'd0, "R4 nop in lock");
        cmd(K_ACT, 2'b10, 1'b0, 3'd0, "R4 act in lock");
        cmd(K_ACT, 2'b10, 1'b0, 3'd0, "R12 rejected act left bank closed");
        cmd(K_REF, 2'b00, 1'b0, 3'd0, "R5 refresh with open bank");
        cmd(K_RD,  2'b01, 1'b0, 3'd0, "R7 read closed bank");
        cmd(K_ACT, 2'b10, 1'b0, 3'd0, "R7 act open bank");
        // auto-precharge burst of length 4 (2 clocks)
        cmd(K_RD,  2'b10, 1'b1, 3'd0, "R6 read auto-precharge");
        cmd(K_WR,  2'b10, 1'b0, 3'd0, "R6 write in burst");
        cmd(K_BST, 2'b00, 1'b0, 3'd0, "R11 burst stop BL4");
        cmd(K_RD,  2'b10, 1'b0, 3'd0, "R6 bank closed after burst");
        // precharge single / all
        cmd(K_ACT, 2'b00, 1'b0, 3'd0, "R2 act bank A");
        cmd(K_ACT, 2'b11, 1'b0, 3'd0, "R2 act bank D");
        cmd(K_PRE, 2'b00, 1'b0, 3'd0, "R8 precharge A");
        cmd(K_RD,  2'b11, 1'b0, 3'd0, "R8 bank D still open");
        cmd(K_PRE, 2'b01, 1'b1, 3'd0, "R8 precharge all");
        cmd(K_RD,  2'b11, 1'b0, 3'd0, "R8 bank D closed by all");
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 3'd7, "R11 deselect");
        cmd(K_MRS, 2'b01, 1'b0, 3'd1, "R3 extended mode set");
        cmd(K_NOP, 2'b00, 1'b0, 3'd0, "R4 lock 1");
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 3'd0, "R4 lock 2 deselect");
        cmd(K_REF, 2'b00, 1'b0, 3'd0, "R1 auto refresh all idle");
        // power-down closed, power-down open, self refresh
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 3'd0, "R10 pd entry closed");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 3'd0, "R10 held low");
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 3'd0, "R10 pd exit");
        cmd(K_ACT, 2'b00, 1'b0, 3'd0, "R2 act A");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 3'd0, "R10 pd entry open");
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 3'd0, "R10 pd exit open");
        cmd(K_MRS, 2'b00, 1'b0, 3'd3, "R5 mode set with open bank");
        cmd(K_PRE, 2'b00, 1'b1, 3'd0, "R8 precharge all");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 3'd0, "R9 self refresh entry");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 3'd0, "R9 held low");
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 3'd0, "R9 self refresh exit");
        // burst length 8: window of 4 clocks
        cmd(K_MRS, 2'b00, 1'b0, 3'd3, "R3 mode set BL8");
        cmd(K_NOP, 2'b00, 1'b0, 3'd0, "R4 lock");
        cmd(K_NOP, 2'b00, 1'b0, 3'd0, "R4 lock");
        cmd(K_ACT, 2'b01, 1'b0, 3'd0, "R2 act C");
        cmd(K_WR,  2'b01, 1'b1, 3'd0, "R6 write auto-precharge");
        cmd(K_RD,  2'b01, 1'b0, 3'd0, "R6 window 1");
        cmd(K_BST, 2'b00, 1'b0, 3'd0, "R11 burst stop BL8");
        cmd(K_NOP, 2'b00, 1'b0, 3'd0, "R6 window 3");
        cmd(K_WR,  2'b01, 1'b0, 3'd0, "R6 window 4");
        cmd(K_ACT, 2'b01, 1'b0, 3'd0, "R6 reopen after burst");
        cmd(K_MRS, 2'b00, 1'b0, 3'd5, "R5 mode set bank open");
        cmd(K_PRE, 2'b01, 1'b0, 3'd0, "R8 precharge C");
        cmd(K_MRS, 2'b00, 1'b0, 3'd5, "R3 mode set op ignored");
        cmd(K_NOP, 2'b00, 1'b0, 3'd0, "R4 lock");
        cmd(K_NOP, 2'b00, 1'b0, 3'd0, "R4 lock");

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [2:0] rcw;
            int op;
            op = $urandom_range(0, 9);
            case (op)
                0: rcw = K_NOP;
                1, 9: rcw = K_ACT;
                2: rcw = K_RD;
                3: rcw = K_WR;
                4: rcw = K_PRE;
                5: rcw = K_BST;
                6: rcw = K_REF;
                7: rcw = ($urandom_range(0, 3) == 0) ? K_MRS : K_ACT;
                default: rcw = K_NOP;
            endcase
            step(1'b1, (op == 8), rcw[2], rcw[1], rcw[0], 2'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), "R1 random");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule